// File: doc/BRIEF.md
# Multi-Event Packet Aggregator with Trigger Throttle

This block sits between the readout path of a pre-processing board and the link toward a computing farm. Event fragments arrive as a valid/ready word stream, each fragment ending on a word flagged as last. They are buffered whole, and several of them are packed into one outgoing packet, so that the farm receives fewer and larger transfers. A packet begins with a three-word header: the destination, the number of events it carries, and the trigger tag of its first event. Each fragment inside the packet is then preceded by a word holding its length.

Destinations are not chosen locally. A fast-control port pushes destination entries into a small queue, and each entry stands for an idle farm node that has asked for work. A packet may only leave once such an entry is available, and it consumes exactly one entry. A packet closes when a configured number of complete fragments is buffered, or when a configured timeout runs out while at least one complete fragment waits. If no destination is available, the ready packet waits in the buffer without loss and a stall counter advances. Buffer occupancy drives a throttle request toward the first-level trigger. The request uses separate assert and release thresholds.

The configuration inputs are expected to stay constant while traffic flows. A fragment must not be longer than the data buffer.

Top module: `pkt_aggregator`

## Requirements
- R1: An outgoing packet is laid out as word 0 = destination address, word 1 = event count, word 2 = trigger tag of its first fragment, each zero-extended to the output width. After the header, every fragment is sent as one length word (its number of data words) followed by its data words in arrival order. `out_last` is high only on the final data word of the packet.
- R2: A packet closes as soon as the number of complete buffered fragments reaches `cfg_evt_per_pkt`, and it then carries exactly that many fragments. A setting of 0 behaves as 1.
- R3: With fewer fragments than the count, a packet closes only after `cfg_timeout` cycles have passed with at least one complete fragment buffered. It then carries all complete fragments buffered at that moment.
- R4: No packet word is presented while the destination queue is empty. Each packet consumes one destination entry, and entries are used in the order they were pushed.
- R5: `stall_cnt` (saturating) increases once per cycle while a closed packet waits for a destination. The waiting packet is later sent complete and unchanged.
- R6: `throttle` rises the cycle after buffered data words reach `cfg_thr_high`, stays high while the occupancy is above `cfg_thr_low`, and falls the cycle after the occupancy drops to `cfg_thr_low` or below.
- R7: While `out_valid` is high and `out_ready` low, `out_data` and `out_last` hold. Fragments are never split across packets, and no data is lost under backpressure.
- R8: `in_ready` is low whenever the data buffer is full or the fragment descriptor queue is full, so no input word is dropped.
- R9: After reset `out_valid`, `throttle` and `stall_cnt` are 0, and `in_ready` and `dst_ready` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_evt_per_pkt | input | FCW | Fragments per packet (0 means 1) |
| cfg_timeout | input | TMO_W | Cycles before a partial packet closes |
| cfg_thr_high | input | OCC_W | Throttle assert threshold, in buffered words |
| cfg_thr_low | input | OCC_W | Throttle release threshold, in buffered words |
| in_valid | input | 1 | Fragment word valid |
| in_ready | output | 1 | Fragment word accepted |
| in_data | input | DATA_W | Fragment data word |
| in_last | input | 1 | Final word of the fragment |
| in_tag | input | TAG_W | Trigger tag, sampled on the fragment's first word |
| dst_valid | input | 1 | Destination entry offered by fast control |
| dst_ready | output | 1 | Destination queue has room |
| dst_addr | input | DST_W | Destination node address |
| out_valid | output | 1 | Packet word valid |
| out_ready | input | 1 | Packet word consumed |
| out_data | output | DATA_W | Packet word |
| out_last | output | 1 | Final word of the packet |
| throttle | output | 1 | Trigger throttle request |
| stall_cnt | output | STALL_W | Cycles spent waiting for a destination |

## Verification
Every cycle, the checker confirms that a stalled output word holds its value and that the buffer never accepts a word when full. It also checks that a packet starts only when a destination entry is queued, that the stall counter never decreases, and that the throttle moves only across its two thresholds. The packet layout, the count and timeout closing rules, the destination order, and the survival of a stalled packet are shown only by the bench. It compares whole observed packets against packets it builds itself, under several fragment sizes, counts and output backpressure patterns.

// File: rtl/agg_pkg.sv
package agg_pkg;

   // Packet assembly phases; the header phases follow the wire order of R1.
   typedef enum logic [2:0] {
      PK_IDLE = 3'd0,
      PK_DST  = 3'd1,
      PK_CNT  = 3'd2,
      PK_TAG  = 3'd3,
      PK_LEN  = 3'd4,
      PK_DATA = 3'd5
   } pk_state_t;

   localparam int HDR_WORDS = 3;

endpackage

// File: rtl/agg_fifo.sv
// Synchronous show-ahead FIFO with occupancy count.
module agg_fifo #(
   parameter  int W     = 8,
   parameter  int DEPTH = 4,
   localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [W-1:0]  wdata,
   input  logic          pop,
   output logic [W-1:0]  rdata,
   output logic [CW-1:0] count,
   output logic          full,
   output logic          empty
);

   localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic          do_push, do_pop;

   assign full    = (count == CW'(DEPTH));
   assign empty   = (count == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign rdata   = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= (wr_ptr == LAST_IDX) ? '0 : wr_ptr + AW'(1);
         if (do_pop)  rd_ptr <= (rd_ptr == LAST_IDX) ? '0 : rd_ptr + AW'(1);
         count <= count + CW'(do_push) - CW'(do_pop);
      end
   end

endmodule

// File: rtl/agg_ingest.sv
// Accepts fragment words, measures each fragment and emits a descriptor on its last word.
module agg_ingest #(
   parameter int DATA_W = 32,
   parameter int TAG_W  = 16,
   parameter int LEN_W  = 6
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   output logic                     in_ready,
   input  logic [DATA_W-1:0]        in_data,
   input  logic                     in_last,
   input  logic [TAG_W-1:0]         in_tag,
   input  logic                     data_full,
   input  logic                     desc_full,
   output logic                     data_push,
   output logic [DATA_W-1:0]        data_wdata,
   output logic                     desc_push,
   output logic [LEN_W+TAG_W-1:0]   desc_wdata
);

   logic [LEN_W-1:0] len_acc;
   logic [TAG_W-1:0] tag_q;
   logic             first_word;
   logic             accept;

   assign in_ready   = !data_full && !desc_full;
   assign accept     = in_valid && in_ready;
   assign first_word = (len_acc == '0);
   assign data_push  = accept;
   assign data_wdata = in_data;
   assign desc_push  = accept && in_last;
   assign desc_wdata = {len_acc + LEN_W'(1), first_word ? in_tag : tag_q};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         len_acc <= '0;
         tag_q   <= '0;
      end else if (accept) begin
         if (first_word) tag_q <= in_tag;
         len_acc <= in_last ? '0 : len_acc + LEN_W'(1);
      end
   end

endmodule

// File: rtl/agg_throttle.sv
// Trigger throttle from buffer occupancy; HYST selects two-threshold or single-threshold form.
module agg_throttle #(
   parameter int OCC_W = 6,
   parameter bit HYST  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [OCC_W-1:0] occ,
   input  logic [OCC_W-1:0] thr_high,
   input  logic [OCC_W-1:0] thr_low,
   output logic             throttle
);

   generate
      if (HYST) begin : g_hyst
         always_ff @(posedge clk) begin
            if (!rst_n)               throttle <= 1'b0;
            else if (occ >= thr_high) throttle <= 1'b1;
            else if (occ <= thr_low)  throttle <= 1'b0;
         end
      end else begin : g_plain
         logic unused_low;
         assign unused_low = ^thr_low;
         always_ff @(posedge clk) begin
            if (!rst_n) throttle <= 1'b0;
            else        throttle <= (occ >= thr_high);
         end
      end
   endgenerate

endmodule

// File: rtl/agg_packer.sv
// Decides when a packet closes, pulls a destination and streams header, length words and data.
module agg_packer
   import agg_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int TAG_W   = 16,
   parameter int DST_W   = 8,
   parameter int LEN_W   = 6,
   parameter int FCW     = 4,
   parameter int DCW     = 3,
   parameter int TMO_W   = 16,
   parameter int STALL_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [FCW-1:0]     cfg_evt,
   input  logic [TMO_W-1:0]   cfg_tmo,
   input  logic [FCW-1:0]     desc_cnt,
   input  logic [LEN_W-1:0]   desc_len,
   input  logic [TAG_W-1:0]   desc_tag,
   input  logic [DCW-1:0]     dst_cnt,
   input  logic [DST_W-1:0]   dst_head,
   input  logic [DATA_W-1:0]  data_head,
   output logic               desc_pop,
   output logic               dst_pop,
   output logic               data_pop,
   output logic               out_valid,
   input  logic               out_ready,
   output logic [DATA_W-1:0]  out_data,
   output logic               out_last,
   output logic [STALL_W-1:0] stall_cnt
);

   pk_state_t        state;
   logic [FCW-1:0]   evt_eff, pkt_sz, pkt_evts, evts_left;
   logic [LEN_W-1:0] words_left;
   logic [TMO_W-1:0] timer;
   logic             enough, expired, closing, have_dst, hs;

   assign evt_eff  = (cfg_evt == '0) ? FCW'(1) : cfg_evt;
   assign enough   = (desc_cnt >= evt_eff);
   assign expired  = (timer >= cfg_tmo) && (desc_cnt != '0);
   assign closing  = (state == PK_IDLE) && (enough || expired);
   assign pkt_sz   = enough ? evt_eff : desc_cnt;
   assign have_dst = (dst_cnt != '0);

   assign out_valid = (state != PK_IDLE);
   assign hs        = out_valid && out_ready;
   assign dst_pop   = hs && (state == PK_DST);
   assign data_pop  = hs && (state == PK_DATA);
   assign desc_pop  = data_pop && (words_left == LEN_W'(1));
   assign out_last  = (state == PK_DATA) && (words_left == LEN_W'(1)) &&
                      (evts_left == FCW'(1));

   always_comb begin
      unique case (state)
         PK_DST:  out_data = DATA_W'(dst_head);
         PK_CNT:  out_data = DATA_W'(pkt_evts);
         PK_TAG:  out_data = DATA_W'(desc_tag);
         PK_LEN:  out_data = DATA_W'(desc_len);
         PK_DATA: out_data = data_head;
         default: out_data = '0;
      endcase
   end

   // Timeout clock: runs only while idle with complete fragments waiting.
   always_ff @(posedge clk) begin
      if (!rst_n || state != PK_IDLE || desc_cnt == '0) timer <= '0;
      else if (timer != '1)                             timer <= timer + TMO_W'(1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= PK_IDLE;
         pkt_evts   <= '0;
         evts_left  <= '0;
         words_left <= '0;
         stall_cnt  <= '0;
      end else begin
         unique case (state)
            PK_IDLE: begin
               if (closing && have_dst) begin
                  pkt_evts  <= pkt_sz;
                  evts_left <= pkt_sz;
                  state     <= PK_DST;
               end else if (closing && stall_cnt != '1) begin
                  stall_cnt <= stall_cnt + STALL_W'(1);
               end
            end
            PK_DST: if (hs) state <= PK_CNT;
            PK_CNT: if (hs) state <= PK_TAG;
            PK_TAG: if (hs) state <= PK_LEN;
            PK_LEN: begin
               if (hs) begin
                  words_left <= desc_len;
                  state      <= PK_DATA;
               end
            end
            PK_DATA: begin
               if (hs) begin
                  if (words_left == LEN_W'(1)) begin
                     evts_left <= evts_left - FCW'(1);
                     state     <= (evts_left == FCW'(1)) ? PK_IDLE : PK_LEN;
                  end else begin
                     words_left <= words_left - LEN_W'(1);
                  end
               end
            end
            default: state <= PK_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/pkt_aggregator.sv
module pkt_aggregator #(
   parameter  int DATA_W     = 32,
   parameter  int TAG_W      = 16,
   parameter  int DST_W      = 8,
   parameter  int BUF_DEPTH  = 32,
   parameter  int FRAG_DEPTH = 8,
   parameter  int DST_DEPTH  = 4,
   parameter  int TMO_W      = 16,
   parameter  int STALL_W    = 16,
   parameter  bit THR_HYST   = 1'b1,
   localparam int OCC_W      = $clog2(BUF_DEPTH + 1),
   localparam int LEN_W      = $clog2(BUF_DEPTH + 1),
   localparam int FCW        = $clog2(FRAG_DEPTH + 1),
   localparam int DCW        = $clog2(DST_DEPTH + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [FCW-1:0]     cfg_evt_per_pkt,
   input  logic [TMO_W-1:0]   cfg_timeout,
   input  logic [OCC_W-1:0]   cfg_thr_high,
   input  logic [OCC_W-1:0]   cfg_thr_low,
   input  logic               in_valid,
   output logic               in_ready,
   input  logic [DATA_W-1:0]  in_data,
   input  logic               in_last,
   input  logic [TAG_W-1:0]   in_tag,
   input  logic               dst_valid,
   output logic               dst_ready,
   input  logic [DST_W-1:0]   dst_addr,
   output logic               out_valid,
   input  logic               out_ready,
   output logic [DATA_W-1:0]  out_data,
   output logic               out_last,
   output logic               throttle,
   output logic [STALL_W-1:0] stall_cnt
);

   localparam int DESC_W = LEN_W + TAG_W;

   initial begin
      if (TAG_W > DATA_W || DST_W > DATA_W || LEN_W > DATA_W || FCW > DATA_W)
         $error("pkt_aggregator: a header field is wider than DATA_W");
      if (BUF_DEPTH < 2 || FRAG_DEPTH < 1 || DST_DEPTH < 1)
         $error("pkt_aggregator: buffer depths too small");
   end

   logic              data_push, data_pop, data_full, data_empty;
   logic [DATA_W-1:0] data_wdata, data_head;
   logic [OCC_W-1:0]  data_cnt;

   logic              desc_push, desc_pop, desc_full, desc_empty;
   logic [DESC_W-1:0] desc_wdata, desc_head;
   logic [FCW-1:0]    desc_cnt;

   logic              dst_pop, dst_full, dst_empty;
   logic [DST_W-1:0]  dst_head;
   logic [DCW-1:0]    dst_cnt;

   assign dst_ready = !dst_full;

   agg_ingest #(.DATA_W(DATA_W), .TAG_W(TAG_W), .LEN_W(LEN_W)) u_ingest (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .in_ready   (in_ready),
      .in_data    (in_data),
      .in_last    (in_last),
      .in_tag     (in_tag),
      .data_full  (data_full),
      .desc_full  (desc_full),
      .data_push  (data_push),
      .data_wdata (data_wdata),
      .desc_push  (desc_push),
      .desc_wdata (desc_wdata)
   );

   agg_fifo #(.W(DATA_W), .DEPTH(BUF_DEPTH)) u_data_q (
      .clk (clk), .rst_n (rst_n),
      .push (data_push), .wdata (data_wdata),
      .pop (data_pop), .rdata (data_head),
      .count (data_cnt), .full (data_full), .empty (data_empty)
   );

   agg_fifo #(.W(DESC_W), .DEPTH(FRAG_DEPTH)) u_desc_q (
      .clk (clk), .rst_n (rst_n),
      .push (desc_push), .wdata (desc_wdata),
      .pop (desc_pop), .rdata (desc_head),
      .count (desc_cnt), .full (desc_full), .empty (desc_empty)
   );

   agg_fifo #(.W(DST_W), .DEPTH(DST_DEPTH)) u_dst_q (
      .clk (clk), .rst_n (rst_n),
      .push (dst_valid), .wdata (dst_addr),
      .pop (dst_pop), .rdata (dst_head),
      .count (dst_cnt), .full (dst_full), .empty (dst_empty)
   );

   agg_packer #(
      .DATA_W (DATA_W), .TAG_W (TAG_W), .DST_W (DST_W), .LEN_W (LEN_W),
      .FCW (FCW), .DCW (DCW), .TMO_W (TMO_W), .STALL_W (STALL_W)
   ) u_packer (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_evt   (cfg_evt_per_pkt),
      .cfg_tmo   (cfg_timeout),
      .desc_cnt  (desc_cnt),
      .desc_len  (desc_head[DESC_W-1:TAG_W]),
      .desc_tag  (desc_head[TAG_W-1:0]),
      .dst_cnt   (dst_cnt),
      .dst_head  (dst_head),
      .data_head (data_head),
      .desc_pop  (desc_pop),
      .dst_pop   (dst_pop),
      .data_pop  (data_pop),
      .out_valid (out_valid),
      .out_ready (out_ready),
      .out_data  (out_data),
      .out_last  (out_last),
      .stall_cnt (stall_cnt)
   );

   agg_throttle #(.OCC_W(OCC_W), .HYST(THR_HYST)) u_throttle (
      .clk      (clk),
      .rst_n    (rst_n),
      .occ      (data_cnt),
      .thr_high (cfg_thr_high),
      .thr_low  (cfg_thr_low),
      .throttle (throttle)
   );

endmodule

// File: rtl/agg_chk.sv
module agg_chk #(
   parameter int DATA_W    = 32,
   parameter int OCC_W     = 6,
   parameter int DCW       = 3,
   parameter int STALL_W   = 16,
   parameter int BUF_DEPTH = 32,
   parameter bit HYST      = 1'b1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               in_valid,
   input logic               in_ready,
   input logic               out_valid,
   input logic               out_ready,
   input logic [DATA_W-1:0]  out_data,
   input logic               out_last,
   input logic               throttle,
   input logic [STALL_W-1:0] stall_cnt,
   input logic [OCC_W-1:0]   data_cnt,
   input logic [DCW-1:0]     dst_cnt,
   input logic [OCC_W-1:0]   cfg_thr_high,
   input logic [OCC_W-1:0]   cfg_thr_low
);

   // R7
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

   // R8
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready |-> data_cnt < OCC_W'(BUF_DEPTH));

   // R4
   dst_needed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> $past(dst_cnt) != '0);

   // R5
   stall_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> stall_cnt >= $past(stall_cnt));

   // R6
   thr_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      data_cnt >= cfg_thr_high |=> throttle);

   generate
      if (HYST) begin : g_hyst_chk
         // R6
         thr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            throttle && data_cnt > cfg_thr_low |=> throttle);
         // R6
         thr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !throttle && data_cnt < cfg_thr_high |=> !throttle);
      end
   endgenerate

endmodule

bind pkt_aggregator agg_chk #(
   .DATA_W (DATA_W), .OCC_W (OCC_W), .DCW (DCW), .STALL_W (STALL_W),
   .BUF_DEPTH (BUF_DEPTH), .HYST (THR_HYST)
) u_agg_chk (
   .clk (clk), .rst_n (rst_n),
   .in_valid (in_valid), .in_ready (in_ready),
   .out_valid (out_valid), .out_ready (out_ready),
   .out_data (out_data), .out_last (out_last),
   .throttle (throttle), .stall_cnt (stall_cnt),
   .data_cnt (data_cnt), .dst_cnt (dst_cnt),
   .cfg_thr_high (cfg_thr_high), .cfg_thr_low (cfg_thr_low)
);

// File: tb/test_pkt_aggregator.sv
module test_pkt_aggregator;

   localparam int CLK_PERIOD = 10;
   localparam int DATA_W = 32, TAG_W = 16, DST_W = 8, BUF_DEPTH = 32;
   localparam int FCW = 4, OCC_W = 6, TMO_W = 16, STALL_W = 16;

   typedef struct packed {
      logic [3:0] evt;
      logic [5:0] len;
      logic [7:0] dst;
      logic [1:0] mode;
   } vec_t;

   localparam int NV = 5;
   localparam vec_t VEC [NV] = '{
      '{4'd1, 6'd1, 8'h11, 2'd1},
      '{4'd3, 6'd2, 8'h22, 2'd1},
      '{4'd4, 6'd3, 8'h33, 2'd2},
      '{4'd0, 6'd5, 8'h44, 2'd1},
      '{4'd2, 6'd7, 8'hA5, 2'd2}
   };

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic [FCW-1:0]     cfg_evt = '0;
   logic [TMO_W-1:0]   cfg_tmo = 16'd1000;
   logic [OCC_W-1:0]   cfg_hi = 6'd40;
   logic [OCC_W-1:0]   cfg_lo = 6'd0;
   logic               in_valid = 1'b0, in_last = 1'b0;
   logic [DATA_W-1:0]  in_data = '0;
   logic [TAG_W-1:0]   in_tag = '0;
   logic               in_ready;
   logic               dst_valid = 1'b0;
   logic [DST_W-1:0]   dst_addr = '0;
   logic               dst_ready;
   logic               out_valid, out_ready = 1'b0, out_last;
   logic [DATA_W-1:0]  out_data;
   logic               throttle;
   logic [STALL_W-1:0] stall_cnt;

   int n_chk = 0, n_fail = 0, n_last = 0, cycles = 0;
   int rdy_mode = 0, grant_req = 0, grant_used = 0;
   bit tog = 1'b0, done = 1'b0;
   logic [DATA_W-1:0] obs [$];
   logic [DATA_W-1:0] exp_q [$];

   always #(CLK_PERIOD / 2) clk = ~clk;

   pkt_aggregator i_pkt_aggregator (
      .clk (clk), .rst_n (rst_n),
      .cfg_evt_per_pkt (cfg_evt), .cfg_timeout (cfg_tmo),
      .cfg_thr_high (cfg_hi), .cfg_thr_low (cfg_lo),
      .in_valid (in_valid), .in_ready (in_ready), .in_data (in_data),
      .in_last (in_last), .in_tag (in_tag),
      .dst_valid (dst_valid), .dst_ready (dst_ready), .dst_addr (dst_addr),
      .out_valid (out_valid), .out_ready (out_ready), .out_data (out_data),
      .out_last (out_last), .throttle (throttle), .stall_cnt (stall_cnt)
   );

   // Output ready pattern: 0 low, 1 high, 2 alternating, 3 granted handshakes only.
   always @(negedge clk) begin
      tog <= ~tog;
      case (rdy_mode)
         1:       out_ready <= 1'b1;
         2:       out_ready <= tog;
         3:       out_ready <= (grant_used < grant_req);
         default: out_ready <= 1'b0;
      endcase
   end

   // Output monitor, sampled after the negedge drive settles.
   always @(negedge clk) begin
      #1;
      if (rst_n && out_valid && out_ready) begin
         obs.push_back(out_data);
         grant_used++;
         if (out_last) n_last++;
      end
   end

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
         summary();
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
      end
   endtask

   function automatic logic [DATA_W-1:0] word_of(input logic [TAG_W-1:0] tag, input int i);
      return {tag, 16'(i)};
   endfunction

   task automatic push_dst(input logic [DST_W-1:0] a);
      @(negedge clk);
      while (!dst_ready) @(negedge clk);
      dst_valid = 1'b1; dst_addr = a;
      @(posedge clk);
      @(negedge clk);
      dst_valid = 1'b0;
   endtask

   task automatic send_frag(input logic [TAG_W-1:0] tag, input int len);
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         in_valid = 1'b1; in_data = word_of(tag, i); in_tag = tag;
         in_last = (i == len - 1);
         while (!in_ready) @(negedge clk);
         @(posedge clk);
      end
      @(negedge clk);
      in_valid = 1'b0; in_last = 1'b0; in_tag = '0;
   endtask

   task automatic exp_hdr(input logic [DST_W-1:0] d, input int n, input logic [TAG_W-1:0] t);
      exp_q.push_back(DATA_W'(d));
      exp_q.push_back(DATA_W'(n));
      exp_q.push_back(DATA_W'(t));
   endtask

   task automatic exp_frag(input logic [TAG_W-1:0] t, input int len);
      exp_q.push_back(DATA_W'(len));
      for (int i = 0; i < len; i++) exp_q.push_back(word_of(t, i));
   endtask

   task automatic wait_last(input int n, input int limit, input string req);
      int k = 0;
      while (n_last < n && k < limit) begin
         @(negedge clk);
         k++;
      end
      chk(n_last >= n, req, "packet end seen", n_last, n);
   endtask

   task automatic compare(input string req);
      int bad = -1;
      if (obs.size() == exp_q.size()) begin
         for (int i = 0; i < obs.size(); i++)
            if (bad < 0 && obs[i] !== exp_q[i]) bad = i;
      end
      if (obs.size() != exp_q.size())
         chk(1'b0, req, "packet word count", obs.size(), exp_q.size());
      else if (bad >= 0)
         chk(1'b0, req, $sformatf("packet word %0d", bad), obs[bad], exp_q[bad]);
      else
         chk(1'b1, req, "packet contents", 0, 0);
      obs.delete(); exp_q.delete(); n_last = 0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9 reset state
      chk(out_valid == 1'b0, "R9", "out_valid", out_valid, 0);
      chk(in_ready == 1'b1, "R9", "in_ready", in_ready, 1);
      chk(dst_ready == 1'b1, "R9", "dst_ready", dst_ready, 1);
      chk(throttle == 1'b0, "R9", "throttle", throttle, 0);
      chk(stall_cnt == '0, "R9", "stall_cnt", stall_cnt, 0);

      // Table walk: R1 layout, R2 count closing, R7 backpressure
      for (int v = 0; v < NV; v++) begin
         int nf;
         nf = (VEC[v].evt == 0) ? 1 : int'(VEC[v].evt);
         cfg_evt = VEC[v].evt;
         rdy_mode = int'(VEC[v].mode);
         push_dst(VEC[v].dst);
         exp_hdr(VEC[v].dst, nf, 16'(16'h100 * (v + 1)));
         for (int f = 0; f < nf; f++) begin
            send_frag(16'(16'h100 * (v + 1) + f), int'(VEC[v].len) + f);
            exp_frag(16'(16'h100 * (v + 1) + f), int'(VEC[v].len) + f);
         end
         wait_last(1, 400, "R2");
         compare("R1");
      end
      rdy_mode = 1;

      // R3 timeout closes a partial packet, not early
      cfg_evt = 4'd4; cfg_tmo = 16'd40;
      push_dst(8'h61);
      send_frag(16'h0777, 2);
      repeat (20) @(negedge clk);
      chk(out_valid == 1'b0 && obs.size() == 0, "R3", "no early close", obs.size(), 0);
      exp_hdr(8'h61, 1, 16'h0777); exp_frag(16'h0777, 2);
      wait_last(1, 100, "R3");
      compare("R3");
      cfg_tmo = 16'd1000;

      // R5/R4 stall without destination, then delivery without loss
      cfg_evt = 4'd2;
      send_frag(16'h0A01, 3);
      send_frag(16'h0A02, 4);
      repeat (10) @(negedge clk);
      chk(out_valid == 1'b0, "R4", "held without destination", out_valid, 0);
      chk(stall_cnt >= 16'd8, "R5", "stall count grew", stall_cnt, 8);
      push_dst(8'h71);
      exp_hdr(8'h71, 2, 16'h0A01); exp_frag(16'h0A01, 3); exp_frag(16'h0A02, 4);
      wait_last(1, 200, "R5");
      compare("R5");

      // R4 destinations used in arrival order
      cfg_evt = 4'd1;
      push_dst(8'h51);
      push_dst(8'h52);
      send_frag(16'h0B01, 2);
      send_frag(16'h0B02, 1);
      exp_hdr(8'h51, 1, 16'h0B01); exp_frag(16'h0B01, 2);
      exp_hdr(8'h52, 1, 16'h0B02); exp_frag(16'h0B02, 1);
      wait_last(2, 200, "R4");
      compare("R4");

      // R6 throttle hysteresis with granted drain
      rdy_mode = 3; grant_req = grant_used;
      cfg_hi = 6'd10; cfg_lo = 6'd4; cfg_evt = 4'd2;
      send_frag(16'h0C01, 6);
      repeat (3) @(negedge clk);
      chk(throttle == 1'b0, "R6", "below high mark", throttle, 0);
      send_frag(16'h0C02, 6);
      repeat (3) @(negedge clk);
      chk(throttle == 1'b1, "R6", "at/above high mark", throttle, 1);
      push_dst(8'h81);
      grant_req = grant_used + 10;
      repeat (30) @(negedge clk);
      chk(throttle == 1'b1, "R6", "held between marks", throttle, 1);
      grant_req = grant_used + 3;
      repeat (20) @(negedge clk);
      chk(throttle == 1'b0, "R6", "released at low mark", throttle, 0);
      grant_req = grant_used + 4;
      exp_hdr(8'h81, 2, 16'h0C01); exp_frag(16'h0C01, 6); exp_frag(16'h0C02, 6);
      wait_last(1, 100, "R6");
      compare("R7");

      // R8 full buffer stops input, nothing lost
      rdy_mode = 0; cfg_evt = 4'd1; cfg_hi = 6'd40;
      send_frag(16'h0D01, BUF_DEPTH);
      @(negedge clk);
      chk(in_ready == 1'b0, "R8", "in_ready low when full", in_ready, 0);
      push_dst(8'h91);
      rdy_mode = 1;
      exp_hdr(8'h91, 1, 16'h0D01); exp_frag(16'h0D01, BUF_DEPTH);
      wait_last(1, 200, "R8");
      compare("R8");
      chk(in_ready == 1'b1, "R8", "in_ready back after drain", in_ready, 1);

      summary();
   end

endmodule